// File: doc/BRIEF.md
# Differential Clock Output Stop Gate

This block gates a bank of eleven differential reference-clock lanes. A single fast reference clock drives an internal half-period divider whose true and complement levels feed every lane. Six active-low request pins, all asynchronous to the clock, can stop lanes. Four of them are each tied to one lane. Two are shared, and each shared pin acts only on the lanes whose stoppable mask bit is set. Register enable bits decide, per lane, whether the output driver is enabled.

Every request pin is synchronized and then debounced against the complement rising edge. A lane that must stop finishes its current high true phase and then parks with both sides low. When a request is withdrawn, every lane freed by it counts the same number of complement edges and restarts on a true rising edge. Lanes freed by the same acceptance therefore resume on the same clock edge, and no high pulse is ever shortened.

Top module: `src_stop_gate`

## Requirements
- R1: A request pin change is accepted only when the two-flop synchronized level is equal at two consecutive complement rising edges. A complement rising edge is a true falling edge, and one period is 2*HALF_CYC clock cycles. A low pulse shorter than one period has no effect on any lane.
- R2: Request bit 0 of the dedicated bus stops lane 0, bit 1 stops lane 1, bit 2 stops lane 3 and bit 3 stops lane 6. The stop mask has no effect on these lanes.
- R3: Shared request B stops lanes 2, 5, 7 and 9, but only those whose stop mask bit is 1. A lane with mask 0 keeps running.
- R4: Shared request A stops lanes 8 and 10, but only those whose stop mask bit is 1.
- R5: A lane being stopped completes its current true high phase and parks with true and complement both low. True and complement are never high together.
- R6: After a stop request is accepted as withdrawn, a stopped lane waits for two complement rising edges and then resumes on the next true rising edge. Lanes released by the same acceptance resume on the same cycle.
- R7: Each drive-enable output equals its enable bit one clock later, whatever the request pins do.
- R8: Lane 4, and any shared-governed lane whose mask bit is 0, runs freely with the complement equal to the inverse of the true level.
- R9: During reset every lane drives true 0 and complement 1, every drive-enable is 1, and all requests are treated as deasserted.
- R10: Every high pulse on a true or complement output lasts exactly HALF_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ded_req_ni | input | 4 | Dedicated stop requests, active low, for lanes 0, 1, 3 and 6 |
| shr_a_ni | input | 1 | Shared stop request A, active low |
| shr_b_ni | input | 1 | Shared stop request B, active low |
| out_en_i | input | 11 | Per-lane driver enable bits |
| stop_msk_i | input | 11 | Per-lane mask that lets a shared request stop the lane |
| clk_t_o | output | 11 | Gated true level per lane |
| clk_c_o | output | 11 | Gated complement level per lane |
| drv_en_o | output | 11 | Per-lane driver enable, low means tri-state |

## Verification
Two events can meet on one lane. A shared request may be re-accepted as asserted while that lane's restart count is still running. A stop may also be decided on the same edge on which another lane, released earlier, is counting toward its resume. Random request holds of 1 to 12 cycles, which are often shorter than the debounce window, provoke both cases. A cycle model of the requirements judges every output on every cycle, and a pulse-width monitor flags any shortened high phase. Directed cases confirm that lanes released together rise in the same cycle.

// File: rtl/src_gate_pkg.sv
package src_gate_pkg;
  localparam int NUM_OUT   = 11;
  localparam int NUM_DED   = 4;
  localparam int NUM_REQ   = NUM_DED + 2;
  localparam int REQ_A     = NUM_DED;
  localparam int REQ_B     = NUM_DED + 1;
  localparam int FREE_LANE = 4;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_D0, SRC_D1, SRC_D2, SRC_D3, SRC_A, SRC_B
  } req_src_e;

  // lane -> governing request; the mapping is fixed by the board wiring
  function automatic req_src_e lane_src(input int k);
    case (k)
      0:             return SRC_D0;
      1:             return SRC_D1;
      3:             return SRC_D2;
      6:             return SRC_D3;
      2, 5, 7, 9:    return SRC_B;
      8, 10:         return SRC_A;
      default:       return SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/phase_gen.sv
module phase_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tog_o,
  output logic phase_o
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_CYC - 1);

  logic [DW-1:0] div_q;
  logic          phase_q;

  assign tog_o   = (div_q == LAST);
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      div_q   <= tog_o ? '0 : div_q + 1'b1;
      if (tog_o) phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/req_filter.sv
module req_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,     // complement rising edge
  input  logic req_ni,
  output logic acc_no
);
  logic s1_q, s2_q, prev_q, acc_q;

  assign acc_no = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      acc_q  <= 1'b1;
    end else begin
      s1_q <= req_ni;
      s2_q <= s1_q;
      if (ce_i) begin
        prev_q <= s2_q;
        if (s2_q == prev_q) acc_q <= s2_q;
      end
    end
  end
endmodule

// File: rtl/stop_route.sv
module stop_route
  import src_gate_pkg::*;
(
  input  logic [NUM_REQ-1:0] act_i,
  input  logic [NUM_OUT-1:0] msk_i,
  output logic [NUM_OUT-1:0] stop_o
);
  always_comb begin
    for (int k = 0; k < NUM_OUT; k++) begin
      case (lane_src(k))
        SRC_D0:  stop_o[k] = act_i[0];
        SRC_D1:  stop_o[k] = act_i[1];
        SRC_D2:  stop_o[k] = act_i[2];
        SRC_D3:  stop_o[k] = act_i[3];
        SRC_A:   stop_o[k] = act_i[REQ_A] & msk_i[k];
        SRC_B:   stop_o[k] = act_i[REQ_B] & msk_i[k];
        default: stop_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/out_lane.sv
module out_lane #(
  parameter int RESTART_PER = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  input  logic phase_i,
  input  logic stop_req_i,
  input  logic en_i,
  output logic t_o,
  output logic c_o,
  output logic drv_o
);
  localparam int CW = $clog2(RESTART_PER + 1);
  localparam logic [CW-1:0] CNT_END = CW'(RESTART_PER);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          t_q, c_q, drv_q;
  logic          phase_nx;

  assign phase_nx = tog_i ? ~phase_i : phase_i;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (stop_req_i) cnt_d = '0;
    if (tog_i && phase_i) begin
      // true falling: park point, also restart count tick
      if (run_q && stop_req_i)                          run_d = 1'b0;
      else if (!run_q && !stop_req_i && cnt_q != CNT_END) cnt_d = cnt_q + 1'b1;
    end else if (tog_i && !phase_i) begin
      if (!run_q && !stop_req_i && cnt_q == CNT_END)      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      t_q   <= 1'b0;
      c_q   <= 1'b1;
      drv_q <= 1'b1;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      t_q   <= run_d & phase_nx;
      c_q   <= run_d & ~phase_nx;
      drv_q <= en_i;
    end
  end

  assign t_o   = t_q;
  assign c_o   = c_q;
  assign drv_o = drv_q;
endmodule

// File: rtl/src_stop_gate.sv
module src_stop_gate
  import src_gate_pkg::*;
#(
  parameter int HALF_CYC    = 2,
  parameter int RESTART_PER = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DED-1:0] ded_req_ni,
  input  logic               shr_a_ni,
  input  logic               shr_b_ni,
  input  logic [NUM_OUT-1:0] out_en_i,
  input  logic [NUM_OUT-1:0] stop_msk_i,
  output logic [NUM_OUT-1:0] clk_t_o,
  output logic [NUM_OUT-1:0] clk_c_o,
  output logic [NUM_OUT-1:0] drv_en_o
);
  logic               tog, phase, ce;
  logic [NUM_REQ-1:0] req_n, acc_n, act;
  logic [NUM_OUT-1:0] stop_req;

  assign req_n = {shr_b_ni, shr_a_ni, ded_req_ni};
  assign ce    = tog & phase;
  assign act   = ~acc_n;

  phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tog_o  (tog),
    .phase_o(phase)
  );

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    req_filter u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ce_i  (ce),
      .req_ni(req_n[r]),
      .acc_no(acc_n[r])
    );
  end

  stop_route u_route (
    .act_i (act),
    .msk_i (stop_msk_i),
    .stop_o(stop_req)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    out_lane #(.RESTART_PER(RESTART_PER)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tog_i     (tog),
      .phase_i   (phase),
      .stop_req_i(stop_req[k]),
      .en_i      (out_en_i[k]),
      .t_o       (clk_t_o[k]),
      .c_o       (clk_c_o[k]),
      .drv_o     (drv_en_o[k])
    );
  end
endmodule

// File: rtl/src_stop_gate_chk.sv
module src_stop_gate_chk
  import src_gate_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DED-1:0] ded_req_ni,
  input logic               shr_a_ni,
  input logic               shr_b_ni,
  input logic [NUM_OUT-1:0] out_en_i,
  input logic [NUM_OUT-1:0] stop_msk_i,
  input logic [NUM_OUT-1:0] clk_t_o,
  input logic [NUM_OUT-1:0] clk_c_o,
  input logic [NUM_OUT-1:0] drv_en_o
);
  assert_park_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_t_o & clk_c_o) == '0);

  assert_drv_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drv_en_o == $past(out_en_i));

  assert_free_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_t_o[FREE_LANE] ^ clk_c_o[FREE_LANE]);

  if (HALF_CYC > 1) begin : g_width
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_k
      assert_true_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_t_o[k]) |=> clk_t_o[k]);
      assert_comp_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_c_o[k]) |=> clk_c_o[k]);
    end
  end
endmodule

bind src_stop_gate src_stop_gate_chk #(.HALF_CYC(HALF_CYC)) u_chk (.*);

// File: tb/tb_src_stop_gate.sv
`timescale 1ns/1ps
module tb_src_stop_gate;
  localparam int N    = 11;
  localparam int HALF = 2;
  localparam int RST  = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   ded_n = 4'hF;
  logic         a_n = 1'b1, b_n = 1'b1;
  logic [N-1:0] en = '1, msk = '0;
  logic [N-1:0] t_o, c_o, drv_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  src_stop_gate #(.HALF_CYC(HALF), .RESTART_PER(RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ded_req_ni(ded_n), .shr_a_ni(a_n), .shr_b_ni(b_n),
    .out_en_i(en), .stop_msk_i(msk), .clk_t_o(t_o), .clk_c_o(c_o), .drv_en_o(drv_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // -1 none, 0..3 dedicated, 4 shared A, 5 shared B
  function automatic int src_of(input int k);
    case (k)
      0: return 0;  1: return 1;  3: return 2;  6: return 3;
      8, 10: return 4;
      2, 5, 7, 9: return 5;
      default: return -1;
    endcase
  endfunction

  // cycle model built from the requirements
  int       m_div; bit m_ph;
  bit [5:0] m_s1, m_s2, m_prev, m_acc;
  bit [N-1:0] m_run, m_t, m_c, m_drv;
  int       m_cnt [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_ph = 0; m_s1 = '1; m_s2 = '1; m_prev = '1; m_acc = '1;
      m_run = '1; m_t = '0; m_c = '1; m_drv = '1;
      for (int k = 0; k < N; k++) m_cnt[k] = 0;
    end else begin
      bit tg, ce, ph_nx, st;
      int s;
      tg = (m_div == HALF - 1);
      ce = tg && m_ph;
      ph_nx = tg ? ~m_ph : m_ph;
      for (int k = 0; k < N; k++) begin
        s = src_of(k);
        st = (s < 0) ? 0 : (s < 4) ? !m_acc[s] : (!m_acc[s] && msk[k]);
        if (st) m_cnt[k] = 0;
        if (ce) begin
          if (m_run[k] && st) m_run[k] = 0;
          else if (!m_run[k] && !st && m_cnt[k] != RST) m_cnt[k]++;
        end else if (tg && !m_ph) begin
          if (!m_run[k] && !st && m_cnt[k] == RST) m_run[k] = 1;
        end
        m_t[k] = m_run[k] & ph_nx;
        m_c[k] = m_run[k] & ~ph_nx;
      end
      m_drv = en;
      for (int r = 0; r < 6; r++) if (ce) begin
        if (m_s2[r] == m_prev[r]) m_acc[r] = m_s2[r];
        m_prev[r] = m_s2[r];
      end
      m_s2 = m_s1;
      m_s1 = {b_n, a_n, ded_n};
      m_div = tg ? 0 : m_div + 1;
      m_ph = ph_nx;
    end
  end

  // per-cycle comparison and pulse width monitor
  int hw_t [N], hw_c [N];
  always @(negedge clk) if (rst_n && !done) begin
    for (int k = 0; k < N; k++) begin
      string tag;
      int s;
      s = src_of(k);
      tag = (s < 0) ? "R8" : (s < 4) ? "R2" : (s == 4) ? "R4" : "R3";
      if (t_o[k] !== m_t[k] || c_o[k] !== m_c[k])
        chk(0, tag, {t_o[k], c_o[k]}, {m_t[k], m_c[k]});
      if (t_o[k]) hw_t[k]++;
      else begin
        if (hw_t[k] != 0) chk(hw_t[k] == HALF, "R10", hw_t[k], HALF);
        hw_t[k] = 0;
      end
      if (c_o[k]) hw_c[k]++;
      else begin
        if (hw_c[k] != 0) chk(hw_c[k] == HALF, "R10", hw_c[k], HALF);
        hw_c[k] = 0;
      end
    end
    chk(drv_o === m_drv, "R7", drv_o, m_drv);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lane_stat(input int k, input int n, output int hi, output int lo2);
    hi = 0; lo2 = 0;
    repeat (n) begin
      @(negedge clk);
      if (t_o[k]) hi++;
      if (!t_o[k] && !c_o[k]) lo2++;
    end
  endtask

  initial begin
    int hi, lo2, hi2, lo22, r2, r5, cyc;
    for (int k = 0; k < N; k++) begin hw_t[k] = 0; hw_c[k] = 0; end
    wait_n(3);
    // R9 reset state
    chk(t_o == '0, "R9", t_o, 0);
    chk(c_o == '1, "R9", c_o, 11'h7FF);
    chk(drv_o == '1, "R9", drv_o, 11'h7FF);
    rst_n = 1'b1;
    wait_n(20);

    // R1: short glitch on shared B is ignored
    msk = 11'h024;
    b_n = 1'b0; wait_n(2); b_n = 1'b1;
    lane_stat(2, 40, hi, lo2);
    chk(lo2 == 0, "R1", lo2, 0);

    // R3: B stops masked lanes 2,5; lane 7 (mask 0) runs
    b_n = 1'b0; wait_n(40);
    lane_stat(2, 16, hi, lo2);
    chk(hi == 0 && lo2 == 16, "R5", lo2, 16);
    lane_stat(5, 16, hi, lo2);
    chk(hi == 0, "R3", hi, 0);
    lane_stat(7, 16, hi, lo2);
    chk(hi == 8 && lo2 == 0, "R3", hi, 8);

    // R6: release, both lanes rise on the same cycle
    b_n = 1'b1; r2 = -1; r5 = -1; cyc = 0;
    while ((r2 < 0 || r5 < 0) && cyc < 80) begin
      @(negedge clk); cyc++;
      if (t_o[2] && r2 < 0) r2 = cyc;
      if (t_o[5] && r5 < 0) r5 = cyc;
    end
    chk(r2 == r5, "R6", r2, r5);
    chk(r2 >= 8 && r2 <= 40, "R6", r2, 20);
    wait_n(20);

    // R2: dedicated bit 2 stops lane 3 only
    ded_n = 4'b1011; msk = '1; wait_n(40);
    lane_stat(3, 16, hi, lo2);
    lane_stat(0, 16, hi2, lo22);
    chk(hi == 0, "R2", hi, 0);
    chk(hi2 == 8, "R2", hi2, 8);
    ded_n = 4'hF; wait_n(40);
    lane_stat(3, 16, hi, lo2);
    chk(hi == 8, "R6", hi, 8);

    // R4: shared A stops lane 8 (mask 1) but not lane 10 (mask 0)
    msk = 11'h100; a_n = 1'b0; wait_n(40);
    lane_stat(8, 16, hi, lo2);
    lane_stat(10, 16, hi2, lo22);
    chk(hi == 0, "R4", hi, 0);
    chk(hi2 == 8, "R4", hi2, 8);
    a_n = 1'b1; wait_n(40);

    // R7 and R8: disable lane 4 with every request low
    ded_n = 4'h0; a_n = 1'b0; b_n = 1'b0; msk = '1;
    en = ~(11'h1 << 4);
    @(negedge clk);
    chk(drv_o == en, "R7", drv_o, en);
    wait_n(30);
    lane_stat(4, 16, hi, lo2);
    chk(hi == 8 && lo2 == 0, "R8", hi, 8);
    chk(drv_o[4] == 1'b0, "R7", drv_o[4], 0);
    ded_n = 4'hF; a_n = 1'b1; b_n = 1'b1; en = '1;
    wait_n(40);

    // random phase, judged by the cycle model every cycle
    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 3000; it++) begin
      int hold;
      hold = 1 + ($urandom % 12);
      ded_n = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
      a_n = ($urandom % 3 != 0);
      b_n = ($urandom % 3 != 0);
      if ($urandom % 16 == 0) msk = N'($urandom);
      if ($urandom % 16 == 0) en = N'($urandom);
      wait_n(hold);
    end
    wait_n(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule